// File: doc/BRIEF.md
# Banked GPIO Data and Direction Registers

This block holds the data and direction state for one or more groups of 32 general-purpose pins. It sits behind a simple word-addressed register bus. Each group has a direction register, an output latch and a readable input register. Software can change single output bits without a read-modify-write: it writes a mask to a set word, which raises the chosen latch bits, or to a clear word, which lowers them. It can also write the whole latch at once.

Each pin is driven as a tri-state pair: an output value from the latch and an output enable, which is the inverse of the direction bit. The input register shows the real pin level through a two-stage synchronizer, whether the pin is an input or an output. A read taken just after an output change can therefore still return the old level. Interrupt edge detection and interrupt status are handled by a companion block, and their words in each group read back as zero here.

Top module: `gpio_banked_regs`

## Requirements
- R1: After reset every direction bit is 1, so every pin is an input and `pin_oe_o` is all zero. Every output latch bit is 0.
- R2: Writing the direction word (word index 0 of a group) stores the whole value. Bit n of `pin_oe_o` is the inverse of the stored direction bit: 1 = input (not driven), 0 = output (driven). Reading the direction word returns the stored value.
- R3: Writing the output-data word (word index 1) replaces the whole output latch. `pin_o` shows the latch one cycle after the write, and reading the word returns it.
- R4: Writing a mask to the set word (word index 2) sets each latch bit whose mask bit is 1. Latch bits whose mask bit is 0 keep their value.
- R5: Writing a mask to the clear word (word index 3) clears each latch bit whose mask bit is 1. Latch bits whose mask bit is 0 keep their value.
- R6: Reading either the set word or the clear word returns the current output latch.
- R7: Reading the input word (word index 4) returns the level on `pin_i`, including for pins that are driven as outputs.
- R8: A pin level is readable in the input word starting with the second rising clock edge after it appears on `pin_i`. After the first edge only, the read still returns the previous level.
- R9: Group g starts at word address 4 + 10*g, which is byte offset 0x10 + 0x28*g. Pin n belongs to group n/32 at bit n mod 32, and a write to one group changes no other group.
- R10: A read from any word that is not one of the five data/direction words returns zero. This covers the group's five interrupt words (indices 5 to 9), the gaps and the words beyond the last group. A write to any such word, or to the input word, changes no register and no pin output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current address (combinational, zero when not reading) |
| pin_i | input | 32*NUM_BANKS | Pin levels seen at the pads |
| pin_o | output | 32*NUM_BANKS | Output latch values driven to the pads |
| pin_oe_o | output | 32*NUM_BANKS | Pad output enables (inverse of direction) |

## Verification
The input synchronizer keeps sampling the pins in the same cycles that a bus write changes the output latch or the direction. When a pin is an output, the latch change returns to the synchronizer through the pin itself. The bench loops each driven pin back to `pin_i` from `pin_o`. It writes the set word and then reads the input word after each of the following edges. The first two reads must show the old level and the next read the new one. The same latency is checked for an externally driven pin whose level changes between edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned BANK_W        = 32;
  localparam int unsigned BASE_WORD     = 4;   // byte 0x10
  localparam int unsigned STRIDE_WORD   = 10;  // byte 0x28
  localparam int unsigned REGS_PER_BANK = 10;
  localparam int unsigned IDX_W         = 4;

  typedef enum logic [IDX_W-1:0] {
    W_DIR      = 4'd0,
    W_OUT      = 4'd1,
    W_SET      = 4'd2,
    W_CLR      = 4'd3,
    W_IN       = 4'd4,
    W_RISE_ON  = 4'd5,
    W_RISE_OFF = 4'd6,
    W_FALL_ON  = 4'd7,
    W_FALL_OFF = 4'd8,
    W_STAT     = 4'd9
  } word_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_hit_o,
  output logic [IDX_W-1:0]     word_idx_o
);
  logic [31:0] addr32;
  logic [IDX_W-1:0] off [NUM_BANKS];

  assign addr32 = 32'(addr_i);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned BASE = BASE_WORD + b * STRIDE_WORD;
    logic [31:0] diff;
    assign diff          = addr32 - 32'(BASE);
    assign bank_hit_o[b] = (addr32 >= 32'(BASE)) && (addr32 < 32'(BASE + REGS_PER_BANK));
    assign off[b]        = bank_hit_o[b] ? diff[IDX_W-1:0] : '0;
  end

  always_comb begin
    word_idx_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) word_idx_o |= off[b];
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[0] <= '0;
        else         stg[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= '0;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [BANK_W-1:0] pin_i,
  output logic [BANK_W-1:0] pin_o,
  output logic [BANK_W-1:0] pin_oe_o
);
  logic [BANK_W-1:0] dir_q, out_q, out_d, in_q;

  always_comb begin
    out_d = out_q;
    if (wr_i) begin
      unique case (idx_i)
        W_OUT:   out_d = wdata_i;
        W_SET:   out_d = out_q | wdata_i;
        W_CLR:   out_d = out_q & ~wdata_i;
        default: out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '1;
      out_q <= '0;
    end else begin
      out_q <= out_d;
      if (wr_i && idx_i == W_DIR) dir_q <= wdata_i;
    end
  end

  gpio_sync #(.WIDTH(BANK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (in_q)
  );

  always_comb begin
    unique case (idx_i)
      W_DIR:               rdata_o = dir_q;
      W_OUT, W_SET, W_CLR: rdata_o = out_q;
      W_IN:                rdata_o = in_q;
      default:             rdata_o = '0;
    endcase
  end

  assign pin_o    = out_q;
  assign pin_oe_o = ~dir_q;
endmodule

// File: rtl/gpio_banked_regs.sv
module gpio_banked_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS      = NUM_BANKS * BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o
);
  logic [NUM_BANKS-1:0] hit;
  logic [IDX_W-1:0]     idx;
  logic [BANK_W-1:0]    bank_rd [NUM_BANKS];

  gpio_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr_i     (addr_i),
    .bank_hit_o (hit),
    .word_idx_o (idx)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.SYNC_STAGES(SYNC_STAGES)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (req_i && we_i && hit[b]),
      .idx_i    (idx),
      .wdata_i  (wdata_i),
      .rdata_o  (bank_rd[b]),
      .pin_i    (pin_i[b*BANK_W +: BANK_W]),
      .pin_o    (pin_o[b*BANK_W +: BANK_W]),
      .pin_oe_o (pin_oe_o[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i)
      for (int b = 0; b < NUM_BANKS; b++)
        if (hit[b]) rdata_o |= bank_rd[b];
  end
endmodule

// File: rtl/gpio_regs_chk.sv
module gpio_regs_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NPINS      = NUM_BANKS * BANK_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic [NPINS-1:0]  pin_i,
  input logic [NPINS-1:0]  pin_o,
  input logic [NPINS-1:0]  pin_oe_o
);
  localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(BASE_WORD + 2);
  localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(BASE_WORD + 3);
  localparam logic [ADDR_W-1:0] A_IN0  = ADDR_W'(BASE_WORD + 4);

  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  // R4
  set_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_SET0) |=> ((pin_o[31:0] & $past(wdata_i)) == $past(wdata_i)));

  // R5
  clr_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == A_CLR0) |=> ((pin_o[31:0] & $past(wdata_i)) == '0));

  // R4
  set_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && req_i && we_i && addr_i == A_SET0) |=>
      ((pin_o[31:0] & ~$past(wdata_i)) == ($past(pin_o[31:0]) & ~$past(wdata_i))));

  // R10
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && !(req_i && we_i)) |=> ($stable(pin_o) && $stable(pin_oe_o)));

  // R8
  in_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SYNC_STAGES == 2 && age == 2'd3 && req_i && !we_i && addr_i == A_IN0) |->
      (rdata_o == $past(pin_i[31:0], 2)));

  // R10
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i < ADDR_W'(BASE_WORD)) |-> (rdata_o == '0));
endmodule

bind gpio_banked_regs gpio_regs_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_gpio_banked_regs.sv
module sim_gpio_banked_regs;
  localparam int NB = 2;
  localparam int AW = 7;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NP-1:0] pin_i, pin_o, pin_oe, ext_lvl = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] m_dir [NB];
  logic [31:0] m_out [NB];

  always #10 clk = ~clk;

  assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext_lvl);

  gpio_banked_regs #(.NUM_BANKS(NB), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe)
  );

  function automatic logic [AW-1:0] wa(int b, int r);
    return AW'(4 + 10 * b + r);
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic check_state(string rq);
    logic [31:0] d;
    for (int b = 0; b < NB; b++) begin
      rd(wa(b, 0), d); chk(rq, "dir word", d, m_dir[b]);
      rd(wa(b, 1), d); chk(rq, "out word", d, m_out[b]);
      chk(rq, "pin_o", pin_o[b*32 +: 32], m_out[b]);
      chk(rq, "pin_oe_o", pin_oe[b*32 +: 32], ~m_dir[b]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, pat;
    for (int b = 0; b < NB; b++) begin m_dir[b] = '1; m_out[b] = '0; end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_state("R1");
    for (int b = 0; b < NB; b++) begin
      rd(wa(b, 2), d); chk("R1", "set word at reset", d, 32'h0);
    end

    // R2 / R9 direction per bank, distinct per bank
    for (int b = 0; b < NB; b++) begin
      for (int p = 0; p < 4; p++) begin
        pat = 32'h1234_5678 * (p + 1) ^ (32'hF0F0_0F0F << b);
        wr(wa(b, 0), pat); m_dir[b] = pat;
        check_state("R2");
      end
    end

    // R3 full latch write, R4/R5 walking set/clear, R6 readback via set/clr words
    for (int b = 0; b < NB; b++) begin
      wr(wa(b, 1), 32'hA5A5_5A5A); m_out[b] = 32'hA5A5_5A5A;
      check_state("R3");
      for (int i = 0; i < 32; i++) begin
        wr(wa(b, 2), 32'h1 << i); m_out[b] |= 32'h1 << i;
        chk("R4", "set walk pin_o", pin_o[b*32 +: 32], m_out[b]);
      end
      chk("R4", "all set", m_out[b], 32'hFFFF_FFFF);
      for (int i = 0; i < 32; i += 3) begin
        wr(wa(b, 3), 32'h3 << i); m_out[b] &= ~(32'h3 << i);
        chk("R5", "clear walk pin_o", pin_o[b*32 +: 32], m_out[b]);
        rd(wa(b, 2), d); chk("R6", "set word readback", d, m_out[b]);
        rd(wa(b, 3), d); chk("R6", "clr word readback", d, m_out[b]);
      end
      check_state("R9");
    end

    // R7 input reads pin level, outputs looped back
    wr(wa(0, 0), 32'h0000_0000); m_dir[0] = '0;
    wr(wa(0, 1), 32'hC3C3_3C3C); m_out[0] = 32'hC3C3_3C3C;
    wr(wa(1, 0), 32'hFFFF_FFFF); m_dir[1] = '1;
    ext_lvl = {32'h0F0F_1234, ~32'hC3C3_3C3C};
    tick(3);
    rd(wa(0, 4), d); chk("R7", "input of driven bank", d, 32'hC3C3_3C3C);
    rd(wa(1, 4), d); chk("R7", "input of external bank", d, 32'h0F0F_1234);

    // R8 latency, driven pin: bit 5 of bank 0 rising via set word
    wr(wa(0, 3), 32'h20); m_out[0] &= ~32'h20;
    tick(3);
    wr(wa(0, 2), 32'h20); m_out[0] |= 32'h20;
    rd(wa(0, 4), d); chk("R8", "after edge 0", d & 32'h20, 32'h0);
    tick(1);
    rd(wa(0, 4), d); chk("R8", "after edge 1", d & 32'h20, 32'h0);
    tick(1);
    rd(wa(0, 4), d); chk("R8", "after edge 2", d & 32'h20, 32'h20);

    // R8 latency, external pin change between edges
    ext_lvl[32 +: 32] = 32'hDEAD_BEEF;
    rd(wa(1, 4), d); chk("R8", "ext before edge", d, 32'h0F0F_1234);
    tick(1);
    rd(wa(1, 4), d); chk("R8", "ext after edge 1", d, 32'h0F0F_1234);
    tick(1);
    rd(wa(1, 4), d); chk("R8", "ext after edge 2", d, 32'hDEAD_BEEF);

    // R10 unmapped sweep: writes of all ones, reads of zero
    wr(wa(0, 0), 32'h00FF_00FF); m_dir[0] = 32'h00FF_00FF;
    wr(wa(0, 1), 32'h0F0F_0F0F); m_out[0] = 32'h0F0F_0F0F;
    wr(wa(1, 0), 32'hFFFF_0000); m_dir[1] = 32'hFFFF_0000;
    wr(wa(1, 1), 32'h1111_2222); m_out[1] = 32'h1111_2222;
    for (int a = 0; a < (1 << AW); a++) begin
      int b, r;
      bit data_word, in_word;
      b = (a - 4) / 10; r = (a - 4) % 10;
      data_word = (a >= 4) && (b < NB) && (r <= 3);
      in_word   = (a >= 4) && (b < NB) && (r == 4);
      if (!data_word) begin
        wr(AW'(a), 32'hFFFF_FFFF);
        if (!in_word) begin
          rd(AW'(a), d); chk("R10", $sformatf("read addr %0d", a), d, 32'h0);
        end
      end
    end
    check_state("R10");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule